// File: doc/BRIEF.md
# Timer Tick Prescaler and Divider

This block produces the count-enable strobes for a five-channel timer array. All of them come from a single peripheral clock. Two 8-bit prescalers divide that clock. The first one drives channels 0 and 1, and the second drives channels 2, 3 and 4. After its prescaler, each channel has a selector of its own that picks one of two things: a power-of-two post-divider, or an external clock input that is already synchronised. The result is one tick strobe per channel, in the peripheral clock domain, that the timer counters use as their count enable.

Software sets the block up through a plain 32-bit register port, with a write strobe, a byte address and data in, and combinational read data out. Changes to the configuration never cut short a period that is already running. A new prescaler value is taken up at the next terminal count of that prescaler. A new channel selection is taken up at the prescaler terminal count that completes that channel's current tick period.

Top module: `tmr_tick_gen`

## Requirements
- R1: After reset, both prescaler fields and every select field read as zero, and tick_o is all zeros while reset is held. With these reset values every channel ticks on every clock cycle.
- R2: The word at byte offset 0x00 holds the prescaler fields. Bits 7:0 drive channels 0 and 1, and bits 15:8 drive channels 2 to 4. Bits 31:16 read as zero, and writes to them are dropped.
- R3: The word at byte offset 0x04 holds one 4-bit select code per channel c, in bits 4c+3:4c. Bits 31:20 read as zero.
- R4: A prescaler field value N divides the peripheral clock by N+1. Channels 0 and 1 share the low field, and channels 2, 3 and 4 share the high field.
- R5: A select code k from 0 to 4 divides the prescaled rate by a further 2^k. Ticks then come every (N+1)·2^k cycles, and each tick is high for one cycle.
- R6: Select code 5 makes the channel tick once for each rising edge of ext_clk_i, one cycle after that edge is first sampled. The prescaler plays no part in this mode.
- R7: Select codes 6 to 15 give the largest divisor, 16.
- R8: A new prescaler value is taken up at the next terminal count of that prescaler. The period in progress finishes at its old length.
- R9: A new select code for a divided channel is taken up at the prescaler terminal count that ends the channel's current tick period. A channel in external mode takes it up at the next terminal count.
- R10: A write to any offset other than 0x00 or 0x04 leaves both configuration words unchanged, and a read from such an offset returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| ext_clk_i | input | 1 | Synchronised external timer clock |
| tick_o | output | 5 | Per-channel single-cycle tick strobes |

## Verification
The bench measures the gap between consecutive ticks on every channel and compares each gap against (N+1)·2^k. The channels are set to different codes so that both shared prescalers show up at once. A block that took the wrong field for a channel group, or the wrong divisor, shows up as a wrong gap. The bench also writes a new value in the middle of a long prescaler period, and separately a new select code in the middle of a divided period. A design that took up the new value right away would produce a gap shorter than 10 or 8, instead of those lengths followed by 3 or 1. Further checks cover code 15, which must divide by 16 and not fall back to external mode, stray-offset writes that must leave the readback unchanged, and the external mode, which must follow the input's own period whatever the prescaler is set to.

// File: rtl/tmr_tick_pkg.sv
package tmr_tick_pkg;

    // Byte offsets of the two configuration words
    localparam int unsigned OFS_PSC = 0;
    localparam int unsigned OFS_SEL = 4;

    // Where a channel's tick strobe comes from
    typedef enum logic {
        SRC_DIV = 1'b0,
        SRC_EXT = 1'b1
    } src_e;

endpackage

// File: rtl/tmr_cfg_regs.sv
module tmr_cfg_regs
    import tmr_tick_pkg::*;
#(
    parameter int NUM_CH  = 5,
    parameter int NUM_PSC = 2,
    parameter int PSC_W   = 8,
    parameter int SEL_W   = 4,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         wdata,
    output logic [DATA_W-1:0]         rdata,
    output logic [NUM_PSC*PSC_W-1:0]  psc_cfg,
    output logic [NUM_CH*SEL_W-1:0]   sel_cfg
);

    localparam int PW = NUM_PSC * PSC_W;
    localparam int SW = NUM_CH * SEL_W;
    localparam int HI = (PW > SW) ? PW : SW;

    typedef struct packed {
        logic [PW-1:0] psc;
        logic [SW-1:0] sel;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic hit_psc, hit_sel;
    logic unused_wdata_hi;

    assign hit_psc = (addr == ADDR_W'(OFS_PSC));
    assign hit_sel = (addr == ADDR_W'(OFS_SEL));
    assign unused_wdata_hi = ^wdata[DATA_W-1:HI];

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && hit_psc) begin
            cfg_d.psc = wdata[PW-1:0];
        end
        if (wr_en && hit_sel) begin
            cfg_d.sel = wdata[SW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_psc) begin
            rdata[PW-1:0] = cfg_q.psc;
        end else if (hit_sel) begin
            rdata[SW-1:0] = cfg_q.sel;
        end
    end

    assign psc_cfg = cfg_q.psc;
    assign sel_cfg = cfg_q.sel;

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PSC_W-1:0] cfg_div,
    output logic             tc
);

    typedef struct packed {
        logic [PSC_W-1:0] cnt;
        logic [PSC_W-1:0] lim;
    } psc_t;

    psc_t st_d, st_q;

    // The terminal count comes from the latched limit, so the live field
    // cannot cut short the period in progress.
    assign tc = (st_q.cnt == st_q.lim);

    always_comb begin
        st_d = st_q;
        if (tc) begin
            st_d.cnt = '0;
            st_d.lim = cfg_div;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tmr_chan_div.sv
module tmr_chan_div
    import tmr_tick_pkg::*;
#(
    parameter int SEL_W    = 4,
    parameter int DIV_BASE = 0,
    parameter int MAX_LOG2 = 4,
    parameter int EXT_LO   = 5,
    parameter int EXT_HI   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_cfg,
    input  logic             psc_tc,
    input  logic             ext_rise,
    output logic             tick
);

    localparam int CNT_W   = MAX_LOG2;
    localparam int NUM_DIV = MAX_LOG2 - DIV_BASE + 1;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [CNT_W-1:0] dcnt;
        logic             tick;
    } ch_t;

    ch_t st_d, st_q;
    src_e src;
    logic [CNT_W-1:0] last_cnt;

    function automatic src_e code_src(input logic [SEL_W-1:0] code);
        if (int'(code) >= EXT_LO && int'(code) <= EXT_HI) begin
            return SRC_EXT;
        end
        return SRC_DIV;
    endfunction

    function automatic logic [CNT_W-1:0] code_last(input logic [SEL_W-1:0] code);
        int lg;
        lg = (int'(code) < NUM_DIV) ? int'(code) + DIV_BASE : MAX_LOG2;
        return CNT_W'((1 << lg) - 1);
    endfunction

    assign src      = code_src(st_q.sel);
    assign last_cnt = code_last(st_q.sel);

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        case (src)
            SRC_EXT: begin
                st_d.tick = ext_rise;
                if (psc_tc) begin
                    st_d.sel  = sel_cfg;
                    st_d.dcnt = '0;
                end
            end
            default: begin
                if (psc_tc) begin
                    if (st_q.dcnt == last_cnt) begin
                        st_d.tick = 1'b1;
                        st_d.dcnt = '0;
                        st_d.sel  = sel_cfg;
                    end else begin
                        st_d.dcnt = st_q.dcnt + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = st_q.tick;

endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
    parameter int NUM_CH   = 5,
    parameter int PSC_W    = 8,
    parameter int SEL_W    = 4,
    parameter int SPLIT_CH = 2,
    parameter int DIV_BASE = 0,
    parameter int MAX_LOG2 = 4,
    parameter int EXT_LO   = 5,
    parameter int EXT_HI   = 5,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ext_clk_i,
    output logic [NUM_CH-1:0] tick_o
);

    localparam int NUM_PSC = 2;

    logic [NUM_PSC*PSC_W-1:0] psc_cfg;
    logic [NUM_CH*SEL_W-1:0]  sel_cfg;
    logic [NUM_PSC-1:0]       psc_tc;
    logic                     ext_d, ext_q;
    logic                     ext_rise;

    tmr_cfg_regs #(
        .NUM_CH (NUM_CH),
        .NUM_PSC(NUM_PSC),
        .PSC_W  (PSC_W),
        .SEL_W  (SEL_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr_en),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .psc_cfg(psc_cfg),
        .sel_cfg(sel_cfg)
    );

    // One edge detector on the external clock, shared by all channels
    always_comb begin
        ext_d = ext_clk_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_q <= 1'b0;
        end else begin
            ext_q <= ext_d;
        end
    end

    assign ext_rise = ext_clk_i & ~ext_q;

    for (genvar g = 0; g < NUM_PSC; g++) begin : g_psc
        tmr_prescaler #(
            .PSC_W(PSC_W)
        ) u_psc (
            .clk    (clk),
            .rst_n  (rst_n),
            .cfg_div(psc_cfg[g*PSC_W +: PSC_W]),
            .tc     (psc_tc[g])
        );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int GRP = (c < SPLIT_CH) ? 0 : 1;
        tmr_chan_div #(
            .SEL_W   (SEL_W),
            .DIV_BASE(DIV_BASE),
            .MAX_LOG2(MAX_LOG2),
            .EXT_LO  (EXT_LO),
            .EXT_HI  (EXT_HI)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel_cfg (sel_cfg[c*SEL_W +: SEL_W]),
            .psc_tc  (psc_tc[GRP]),
            .ext_rise(ext_rise),
            .tick    (tick_o[c])
        );
    end

endmodule

// File: rtl/tmr_tick_gen_chk.sv
module tmr_tick_gen_chk #(
    parameter int NUM_CH   = 5,
    parameter int PSC_W    = 8,
    parameter int SEL_W    = 4,
    parameter int SPLIT_CH = 2,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      reg_wr_en,
    input logic [ADDR_W-1:0]         reg_addr,
    input logic [DATA_W-1:0]         reg_wdata,
    input logic [NUM_CH-1:0]         tick_o,
    input logic [1:0]                psc_tc,
    input logic                      ext_rise,
    input logic [2*PSC_W-1:0]        psc_cfg,
    input logic [NUM_CH*SEL_W-1:0]   sel_cfg
);

    localparam int PW = 2 * PSC_W;
    localparam int SW = NUM_CH * SEL_W;

    // R1: configuration is zero at the moment reset is released
    assert_reset_zero_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (psc_cfg == '0 && sel_cfg == '0));

    // R2: prescaler word write lands on the next edge
    assert_psc_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == ADDR_W'(0)) |=> (psc_cfg == $past(reg_wdata[PW-1:0])));

    // R3: select word write lands on the next edge
    assert_sel_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == ADDR_W'(4)) |=> (sel_cfg == $past(reg_wdata[SW-1:0])));

    // R10: writes elsewhere leave the configuration untouched
    assert_stray_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr != ADDR_W'(0) && reg_addr != ADDR_W'(4))
        |=> ($stable(psc_cfg) && $stable(sel_cfg)));

    // R5, R6: a tick is always caused by a prescaler terminal count or an external edge
    for (genvar c = 0; c < NUM_CH; c++) begin : g_tick
        localparam int GRP = (c < SPLIT_CH) ? 0 : 1;
        assert_tick_cause_R5_R6: assert property (@(posedge clk) disable iff (!rst_n)
            tick_o[c] |-> $past(psc_tc[GRP] | ext_rise));
    end

endmodule

bind tmr_tick_gen tmr_tick_gen_chk #(
    .NUM_CH  (NUM_CH),
    .PSC_W   (PSC_W),
    .SEL_W   (SEL_W),
    .SPLIT_CH(SPLIT_CH),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr_en(reg_wr_en),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .tick_o   (tick_o),
    .psc_tc   (psc_tc),
    .ext_rise (ext_rise),
    .psc_cfg  (psc_cfg),
    .sel_cfg  (sel_cfg)
);

// File: tb/tb_tmr_tick_gen.sv
module tb_tmr_tick_gen;

    localparam int NCH = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ext_clk = 1'b0;
    logic [NCH-1:0] tick;

    always #10 clk = ~clk;

    tmr_tick_gen dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr_en(wr_en),
        .reg_addr (addr),
        .reg_wdata(wdata),
        .reg_rdata(rdata),
        .ext_clk_i(ext_clk),
        .tick_o   (tick)
    );

    int     n_cmp = 0;
    int     n_bad = 0;
    bit     done = 0;
    longint cyc = 0;
    int     exp_q [NCH][$];
    bit     last_v [NCH];
    longint last_t [NCH];
    bit     ext_on = 0;
    int     ext_cnt = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    // Monitor: compares tick spacing against queued expectations
    always @(negedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (tick[c]) begin
                if (last_v[c] && exp_q[c].size() > 0) begin
                    int e;
                    e = exp_q[c].pop_front();
                    chk(int'(cyc - last_t[c]) == e, $sformatf("R4/R5 tick gap ch%0d", c),
                        cyc - last_t[c], e);
                end
                last_t[c] = cyc;
                last_v[c] = 1'b1;
            end
        end
    end

    // External clock source, period 6 cycles when enabled
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (ext_on) begin
                ext_cnt = (ext_cnt + 1) % 6;
                ext_clk = (ext_cnt < 3);
            end else begin
                ext_clk = 1'b0;
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        step();
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic arm(input int c, input int e, input int n);
        last_v[c] = 1'b0;
        for (int i = 0; i < n; i++) exp_q[c].push_back(e);
    endtask

    task automatic drain();
        int left;
        for (int i = 0; i < 20000; i++) begin
            left = 0;
            for (int c = 0; c < NCH; c++) left += exp_q[c].size();
            if (left == 0) break;
            step();
        end
        for (int c = 0; c < NCH; c++) begin
            if (exp_q[c].size() > 0) begin
                chk(1'b0, $sformatf("tick timeout ch%0d", c), 0, exp_q[c].size());
                exp_q[c].delete();
            end
        end
    endtask

    task automatic wait_tick(input int c);
        do step(); while (!tick[c]);
    endtask

    initial begin
        logic [31:0] rv;
        for (int c = 0; c < NCH; c++) begin
            last_v[c] = 1'b0;
            last_t[c] = 0;
        end
        repeat (3) step();
        // R1: outputs and configuration during reset
        chk(tick == '0, "R1 tick in reset", tick, 0);
        reg_rd(8'h00, rv);
        chk(rv == 32'h0, "R1 prescaler reset", rv, 0);
        reg_rd(8'h04, rv);
        chk(rv == 32'h0, "R1 select reset", rv, 0);
        rst_n = 1'b1;
        step();
        step();
        chk(tick == '1, "R1 tick every cycle after reset", tick, 5'h1f);
        for (int c = 0; c < NCH; c++) arm(c, 1, 3);
        drain();

        // R2: prescaler word readback, upper half dropped
        reg_wr(8'h00, 32'hABCD_3412);
        reg_rd(8'h00, rv);
        chk(rv == 32'h0000_3412, "R2 prescaler readback", rv, 32'h0000_3412);
        // R3: select word readback, bits above 19 dropped
        reg_wr(8'h04, 32'hFFF4_3210);
        reg_rd(8'h04, rv);
        chk(rv == 32'h0004_3210, "R3 select readback", rv, 32'h0004_3210);
        // R10: stray writes and reads
        reg_wr(8'h08, 32'hFFFF_FFFF);
        reg_wr(8'h01, 32'hFFFF_FFFF);
        reg_rd(8'h00, rv);
        chk(rv == 32'h0000_3412, "R10 prescaler kept", rv, 32'h0000_3412);
        reg_rd(8'h04, rv);
        chk(rv == 32'h0004_3210, "R10 select kept", rv, 32'h0004_3210);
        reg_rd(8'h08, rv);
        chk(rv == 32'h0, "R10 stray read zero", rv, 0);

        // R4, R5, R7: low=3, high=4; codes 0,2,1,4,7
        reg_wr(8'h00, 32'h0000_0403);
        reg_wr(8'h04, 32'h0007_4120);
        repeat (400) step();
        arm(0, 4, 3);
        arm(1, 16, 3);
        arm(2, 10, 3);
        arm(3, 80, 3);
        arm(4, 80, 3);   // R7: code 7 divides by 16
        drain();

        // R4, R5, R7: low=255, high=0; codes 3,0,0,2,15
        reg_wr(8'h00, 32'h0000_00FF);
        reg_wr(8'h04, 32'h000F_2003);
        repeat (400) step();
        arm(0, 2048, 3);
        arm(1, 256, 3);
        arm(2, 1, 3);
        arm(3, 4, 3);
        arm(4, 16, 3);   // R7: code 15 divides by 16
        drain();

        // R8: prescaler change in mid-period
        reg_wr(8'h00, 32'h0000_0009);
        reg_wr(8'h04, 32'h0000_0000);
        repeat (2600) step();
        wait_tick(0);
        reg_wr(8'h00, 32'h0000_0002);
        arm(0, 10, 1);   // R8: running period keeps old length
        exp_q[0].push_back(3);
        exp_q[0].push_back(3);
        last_v[0] = 1'b1;
        drain();

        // R9: select change in mid-period on channel 2 (high prescaler = 0)
        reg_wr(8'h04, 32'h0000_0300);
        repeat (50) step();
        wait_tick(2);
        reg_wr(8'h04, 32'h0000_0000);
        arm(2, 8, 1);    // R9: divide-by-8 period completes first
        exp_q[2].push_back(1);
        exp_q[2].push_back(1);
        last_v[2] = 1'b1;
        drain();

        // R6: channels 1 and 4 follow the external clock; channel 0 stays divided
        ext_on = 1'b1;
        reg_wr(8'h00, 32'h0000_FF02);
        reg_wr(8'h04, 32'h0005_0050);
        repeat (600) step();
        arm(1, 6, 3);
        arm(4, 6, 3);
        arm(0, 3, 3);
        drain();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule